// File: doc/BRIEF.md
# Edge-Triggered Interrupt Pulse Controller

This block gathers a parameterised number of event flags into a sticky status register and tells the processor about them with a single-cycle interrupt pulse, not a held level. Each flag source raises a one-cycle set strobe, and the matching status bit latches. Software services the interrupt by reading the status word, handling the bits it finds set, and then writing ones to clear them.

A second register holds one enable bit per flag and one global enable. The pulse fires only when the set of flags that are both enabled and pending goes from empty to non-empty. After that, the controller stays quiet until the set empties or software clears any pending status bit. A clear re-arms the controller, so if enabled flags are still pending after the clear, a fresh pulse follows. Software therefore never misses flags that were left set when its service routine returned.

Top module: `irq_pulse_ctrl`

## Requirements
- R1: After reset the status bits, the per-flag enables, the global enable and `irq_pulse` are all 0.
- R2: A high `flag_set[i]` latches status bit i at the clock edge. This happens whatever the enables are, and the bit reads back as 1 from the status address (`reg_addr` = 0, bit i of `reg_rdata`) in the following cycles.
- R3: A write to the status address clears every status bit whose `reg_wdata` bit is 1. Status bits whose `reg_wdata` bit is 0 keep their value. Bit `NUM_FLAGS` of a status read is always 0.
- R4: If a set strobe and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R5: A write to the enable address (`reg_addr` = 1) loads the per-flag enables from `reg_wdata[NUM_FLAGS-1:0]` and the global enable from `reg_wdata[NUM_FLAGS]`, and a read there returns them in the same positions. A write to any other address changes no register.
- R6: `irq_pulse` is high for one cycle: the cycle after the first cycle in which the global enable is set and at least one enabled status bit reads 1, provided the pulse was not already issued for that pending period.
- R7: Latching more status bits while an enabled flag is already pending produces no further pulse.
- R8: A write-1 clear that clears at least one set status bit re-arms the pulse. If enabled flags are still pending after the clear, `irq_pulse` rises two cycles after the write cycle.
- R9: Setting the global enable while enabled flags are pending produces a pulse. While the global enable is 0, no pulse fires.
- R10: A status bit whose own enable is 0 never causes a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set | input | NUM_FLAGS | One-cycle set strobes, one per flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select: 0 status, 1 enable |
| reg_wdata | input | NUM_FLAGS+1 | Write data |
| reg_rdata | output | NUM_FLAGS+1 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | Single-cycle interrupt pulse |

## Verification
Two things can land on a status bit in one cycle: a flag source setting it and software clearing it with a write-1. The same cycle can also carry a re-arm of the pulse logic and an incoming set of another flag. Directed cases put a strobe and a clear on the same bit in one cycle, and random traffic overlaps strobes with status writes often. Each cycle, the outcome is judged against a reference model built from the requirements: the bit must read back set, and a pulse must appear two cycles later only if an actually cleared bit re-armed the logic while enabled flags stayed pending.

// File: rtl/irq_pulse_pkg.sv
package irq_pulse_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_NONE   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic                 clr_wr_i,
    input  logic [NUM_FLAGS-1:0] clr_data_i,
    output logic [NUM_FLAGS-1:0] status_o,
    output logic                 cleared_any_o
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] status;
    } bank_t;

    bank_t state_d, state_q;
    logic [NUM_FLAGS-1:0] clr_mask;
    logic [NUM_FLAGS-1:0] dropped;

    always_comb begin
        clr_mask = clr_wr_i ? clr_data_i : '0;
        dropped  = state_q.status & clr_mask & ~set_i;
        state_d  = state_q;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (set_i[i]) begin
                state_d.status[i] = 1'b1;
            end else if (clr_mask[i]) begin
                state_d.status[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o      = state_q.status;
    assign cleared_any_o = |dropped;

    // R4: every strobed bit is set after the edge, even under a clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        |set_i |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R3: bits cleared without a competing strobe read 0 afterwards
    p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((status_o & $past(clr_data_i & ~set_i)) == '0));

    // R3: a bit only falls when it was cleared
    p_no_spurious_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status_o & $past(status_o) & ~$past(clr_mask)) == '0));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [NUM_FLAGS:0]   wdata_i,
    output logic [NUM_FLAGS-1:0] en_o,
    output logic                 gen_o
);

    typedef struct packed {
        logic                 gen;
        logic [NUM_FLAGS-1:0] en;
    } enable_t;

    enable_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.en  = wdata_i[NUM_FLAGS-1:0];
            state_d.gen = wdata_i[NUM_FLAGS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o  = state_q.en;
    assign gen_o = state_q.gen;

    // R5: enables move only on a write to their address
    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(en_o) && $stable(gen_o)));

    // R5: a write loads exactly the written value
    p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ({gen_o, en_o} == $past(wdata_i)));

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic rearm_i,
    output logic irq_o
);

    typedef struct packed {
        logic fired;
        logic irq;
    } pulse_t;

    pulse_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.irq   = pending_i && !state_q.fired;
        state_d.fired = pending_i && !rearm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.irq;

    // R6: a pulse is always preceded by a pending cycle
    p_pulse_from_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !irq_o);

    // R7: once issued and not re-armed, no further pulse
    p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.fired && pending_i && !rearm_i) |=> !irq_o);

    // R8: re-armed pending period yields a pulse two cycles on
    p_rearm_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i && rearm_i) |=> (!pending_i || irq_o) or (pending_i ##1 irq_o));

endmodule

// File: rtl/irq_pulse_ctrl.sv
module irq_pulse_ctrl #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flag_set,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_FLAGS:0]   reg_wdata,
    output logic [NUM_FLAGS:0]   reg_rdata,
    output logic                 irq_pulse
);
    import irq_pulse_pkg::*;

    localparam int REG_W = NUM_FLAGS + 1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(1);

    reg_sel_e             sel;
    logic [NUM_FLAGS-1:0] status;
    logic [NUM_FLAGS-1:0] enables;
    logic                 global_en;
    logic                 cleared_any;
    logic                 pending;
    logic [REG_W-1:0]     rdata_mux;

    always_comb begin
        if (reg_addr == ADDR_STATUS) begin
            sel = SEL_STATUS;
        end else if (reg_addr == ADDR_ENABLE) begin
            sel = SEL_ENABLE;
        end else begin
            sel = SEL_NONE;
        end
    end

    irq_status_bank #(.NUM_FLAGS(NUM_FLAGS)) status_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (flag_set),
        .clr_wr_i     (reg_wr && (sel == SEL_STATUS)),
        .clr_data_i   (reg_wdata[NUM_FLAGS-1:0]),
        .status_o     (status),
        .cleared_any_o(cleared_any)
    );

    irq_enable_reg #(.NUM_FLAGS(NUM_FLAGS)) enable_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr && (sel == SEL_ENABLE)),
        .wdata_i(reg_wdata),
        .en_o   (enables),
        .gen_o  (global_en)
    );

    assign pending = global_en && |(status & enables);

    irq_pulse_gen pulse_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending_i(pending),
        .rearm_i  (cleared_any),
        .irq_o    (irq_pulse)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: rdata_mux = {1'b0, status};
            SEL_ENABLE: rdata_mux = {global_en, enables};
            default:    rdata_mux = '0;
        endcase
    end

    assign reg_rdata = rdata_mux;

    // R9: no pulse can follow a cycle with the global enable low
    p_global_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |=> !irq_pulse);

    // R10: flags without their own enable cannot raise a pulse
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & enables) == '0) |=> !irq_pulse);

endmodule

// File: tb/irq_pulse_ctrl_tb_top.sv
module irq_pulse_ctrl_tb_top;

    localparam int N  = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  flag_set = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [N:0]    reg_wdata = '0;
    logic [N:0]    reg_rdata;
    logic          irq_pulse;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_st, m_en;
    logic         m_gen, m_fired, m_irq;

    always #2 clk = ~clk;

    irq_pulse_ctrl #(.NUM_FLAGS(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pulse(irq_pulse)
    );

    function automatic logic [N:0] model_read(input logic [AW-1:0] a);
        if (a == 0) return {1'b0, m_st};
        if (a == 1) return {m_gen, m_en};
        return '0;
    endfunction

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic         pend;
        logic [N-1:0] cmask, dropped;
        pend    = m_gen && |(m_st & m_en);
        cmask   = (reg_wr && reg_addr == 0) ? reg_wdata[N-1:0] : '0;
        dropped = m_st & cmask & ~flag_set;
        m_irq   = pend && !m_fired;
        m_fired = pend && (dropped == '0);
        m_st    = (m_st & ~cmask) | flag_set;
        if (reg_wr && reg_addr == 1) begin
            m_en  = reg_wdata[N-1:0];
            m_gen = reg_wdata[N];
        end
    endtask

    // drive at negedge, check current outputs, advance model, wait edge
    task automatic cyc(input string tag, input logic [N-1:0] s, input logic w,
                       input logic [AW-1:0] a, input logic [N:0] d);
        @(negedge clk);
        flag_set = s; reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        check({tag, " irq"}, {{N{1'b0}}, irq_pulse}, {{N{1'b0}}, m_irq});
        check({tag, " rdata"}, reg_rdata, model_read(a));
        model_step();
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, '0, 1'b0, 2'd0, '0);
    endtask

    initial begin
        m_st = '0; m_en = '0; m_gen = 1'b0; m_fired = 1'b0; m_irq = 1'b0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq", {{N{1'b0}}, irq_pulse}, '0);
        check("R1 status", reg_rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: enable register clear after reset
        cyc("R1", '0, 1'b0, 2'd1, '0);
        // R2 / R10: latch with nothing enabled, no pulse
        cyc("R2", 8'h01, 1'b0, 2'd0, '0);
        idle("R10", 3);
        // R10: global on, flag0 disabled, only flag1 enabled
        cyc("R10", '0, 1'b1, 2'd1, {1'b1, 8'h02});
        idle("R10", 3);
        // R9: global off with flag enabled, then raise global
        cyc("R9", '0, 1'b1, 2'd1, {1'b0, 8'h01});
        idle("R9", 3);
        cyc("R9", '0, 1'b1, 2'd1, {1'b1, 8'hFF});
        idle("R9", 3);
        // R7: more flags while pending
        cyc("R7", 8'h06, 1'b0, 2'd0, '0);
        idle("R7", 3);
        // R3: write zeros has no effect
        cyc("R3", '0, 1'b1, 2'd0, '0);
        idle("R3", 2);
        // R8: clear one bit, others remain -> pulse two cycles after
        cyc("R8", '0, 1'b1, 2'd0, {1'b0, 8'h01});
        idle("R8", 3);
        // R4: set and clear same bit same cycle
        cyc("R4", 8'h10, 1'b1, 2'd0, {1'b0, 8'h10});
        idle("R4", 2);
        // R5: write to unused address changes nothing
        cyc("R5", '0, 1'b1, 2'd2, {1'b1, 8'h00});
        cyc("R5", '0, 1'b0, 2'd1, '0);
        cyc("R5", '0, 1'b0, 2'd3, '0);
        // R3 / R6: clear everything then set again -> new pulse
        cyc("R3", '0, 1'b1, 2'd0, {1'b0, 8'hFF});
        idle("R3", 2);
        cyc("R6", 8'h80, 1'b0, 2'd0, '0);
        idle("R6", 4);
        // random traffic, R6 R7 R8 overlap
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] s;
            logic         w;
            logic [AW-1:0] a;
            logic [N:0]   d;
            s = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
            w = ($urandom_range(0, 2) == 0);
            a = AW'($urandom_range(0, 3));
            d = (N+1)'($urandom);
            if (a == 1 && $urandom_range(0, 3) != 0) d[N] = 1'b1;
            cyc("R6", s, w, a, d);
        end
        idle("R6", 3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule